// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide host side of a three-channel interval timer. The host makes accesses with a 2-bit address. Addresses 0 to 2 reach the data ports of channels 0 to 2. Address 3 is the control port, where the host writes control words and read-back commands.

For each channel the block keeps the access configuration and the count and status latches. It also steps the low/high byte order for reads and for writes. Each channel has a 16-bit down counter that decrements on its own tick enable, together with an output bit that marks when the count has run out. These let the host observe latching and reloads. Every access is acknowledged one cycle after it is presented, and the read data is registered.

Waveform modes and gate inputs are not modelled. The mode field is stored and reported in the status byte only.

Top module: `pit_regs_top`

## Requirements
- R1: An access presented with `bus_sel_i` high is acknowledged by `bus_ack_o` on the next cycle, and `bus_rdata_o` is valid in that cycle. A read of address 3 returns 0x00.
- R2: A control word to address 3 has a channel field in bits 7:6 (value 3 is a read-back command), an access field in bits 5:4 (0 count latch, 1 low byte only, 2 high byte only, 3 low then high), a mode field in bits 3:1 and a decimal flag in bit 0. When the access field is nonzero, the word stores access, mode and decimal flag for that channel and restarts both the read and the write byte order at the low byte.
- R3: A control word with access field 0 copies the live count of the named channel into its count latch. The latched value is then held while the counter keeps running.
- R4: A count-latch request is ignored while a latched count is still unread. A status-latch request is ignored while a latched status is still unread.
- R5: A read-back command (bits 7:6 = 3) selects channel n with bit n+1. When bit 5 is 0, each selected channel latches its count. When bit 4 is 0, each selected channel latches its status.
- R6: The status byte holds the channel output bit in bit 7, 0 in bit 6, the access field in bits 5:4, the mode in bits 3:1 and the decimal flag in bit 0.
- R7: A data-port read returns a pending status first and clears it. If no status is pending, it returns a pending latched count. If neither is pending, it returns the live count.
- R8: A latched count is returned according to the access field in force when it was latched. With low then high, the low byte comes first and the high byte second, and the latch is released after the high byte. With a single-byte access field, that one byte is returned and the latch is released.
- R9: Live-count reads with low then high access alternate between the low byte and the high byte. Low-only access always returns the low byte, and high-only access always returns the high byte.
- R10: With low then high access, a data write holds the first byte and loads {second, first} on the second write. A low-only write loads {0x00, byte}, and a high-only write loads {byte, 0x00}.
- R11: A loaded value of 0 acts as 65536. One tick after loading 0, the count reads 0xFFFF and the output bit stays 0.
- R12: A channel's count decrements by one on each cycle its `tick_i` bit is high. Its `out_o` bit goes to 1 on the tick that takes the count from 1 to 0. A load clears the output bit, and a load has priority over a tick in the same cycle.
- R13: After reset, every channel has low then high access, mode 0, decimal flag 0, count 0 (65536), output 0, no pending latches, and both byte orders at the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Access strobe, one access per cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | 0..2 channel data ports, 3 control port |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| bus_ack_o | output | 1 | Acknowledge, one cycle after the strobe |
| tick_i | input | 3 | Per-channel count enables |
| out_o | output | 3 | Per-channel output bits |

## Verification
The bench builds the block with its default 16-bit counter and byte-wide bus. This brings the 65536 encoding of a zero load within reach with a single tick, and the wrap through 0xFFFF with it. The bench drives the three tick enables separately, so it can run counters underneath pending latches and show that the latched values and status stay frozen while the live counts move. Random runs mix read-back commands that overlap with pending latches, so the ignore-when-pending rules and the read priority are exercised across all channels.

// File: rtl/pit_regs_pkg.sv
package pit_regs_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int NUM_CH = 3;

  localparam logic [1:0] ACC_LATCH = 2'd0;
  localparam logic [1:0] ACC_LO    = 2'd1;
  localparam logic [1:0] ACC_HI    = 2'd2;
  localparam logic [1:0] ACC_WORD  = 2'd3;
  localparam logic [1:0] CTL_ADDR  = 2'd3;

  typedef struct packed {
    logic [1:0] acc;
    logic [2:0] mode;
    logic       bcd;
  } chan_cfg_t;
endpackage

// File: rtl/pit_down_counter.sv
module pit_down_counter
  import pit_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             out_q, out_d;
  logic             cnt_en;

  assign cnt_en = load_i | tick_i;

  always_comb begin
    count_d = count_q;
    out_d   = out_q;
    if (load_i) begin
      count_d = load_val_i;
      out_d   = 1'b0;
    end else if (tick_i) begin
      count_d = count_q - 1'b1;
      if (count_q == CNT_W'(1)) out_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      out_q   <= 1'b0;
    end else if (cnt_en) begin
      count_q <= count_d;
      out_q   <= out_d;
    end
  end

  assign count_o = count_q;
  assign out_o   = out_q;
endmodule

// File: rtl/pit_chan_regs.sv
module pit_chan_regs
  import pit_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_i,
  input  logic [BYTE_W-1:0] cfg_byte_i,
  input  logic              cnt_latch_i,
  input  logic              st_latch_i,
  input  logic              data_wr_i,
  input  logic              data_rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              out_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [1:0]        cl_pend_o,
  output logic [CNT_W-1:0]  cl_val_o,
  output logic              st_pend_o,
  output logic [BYTE_W-1:0] st_val_o
);
  chan_cfg_t         cfg_q, cfg_d;
  logic              rd_hi_q, rd_hi_d, wr_hi_q, wr_hi_d;
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic [1:0]        cl_pend_q, cl_pend_d;
  logic [CNT_W-1:0]  cl_val_q, cl_val_d;
  logic              st_pend_q, st_pend_d;
  logic [BYTE_W-1:0] st_val_q, st_val_d;

  always_comb begin
    cfg_d      = cfg_q;
    rd_hi_d    = rd_hi_q;
    wr_hi_d    = wr_hi_q;
    hold_d     = hold_q;
    cl_pend_d  = cl_pend_q;
    cl_val_d   = cl_val_q;
    st_pend_d  = st_pend_q;
    st_val_d   = st_val_q;
    load_o     = 1'b0;
    load_val_o = '0;
    rdata_o    = '0;

    // read path: status, then latched count, then live count
    if (st_pend_q) begin
      rdata_o = st_val_q;
      if (data_rd_i) st_pend_d = 1'b0;
    end else if (cl_pend_q != ACC_LATCH) begin
      case (cl_pend_q)
        ACC_LO: begin
          rdata_o = cl_val_q[BYTE_W-1:0];
          if (data_rd_i) cl_pend_d = ACC_LATCH;
        end
        ACC_HI: begin
          rdata_o = cl_val_q[CNT_W-1:BYTE_W];
          if (data_rd_i) cl_pend_d = ACC_LATCH;
        end
        default: begin
          rdata_o = cl_val_q[BYTE_W-1:0];
          if (data_rd_i) cl_pend_d = ACC_HI;
        end
      endcase
    end else begin
      case (cfg_q.acc)
        ACC_LO:  rdata_o = count_i[BYTE_W-1:0];
        ACC_HI:  rdata_o = count_i[CNT_W-1:BYTE_W];
        default: begin
          rdata_o = rd_hi_q ? count_i[CNT_W-1:BYTE_W] : count_i[BYTE_W-1:0];
          if (data_rd_i) rd_hi_d = ~rd_hi_q;
        end
      endcase
    end

    // latch requests, dropped while a previous latch is unread
    if (cnt_latch_i && cl_pend_q == ACC_LATCH) begin
      cl_pend_d = cfg_q.acc;
      cl_val_d  = count_i;
    end
    if (st_latch_i && !st_pend_q) begin
      st_pend_d = 1'b1;
      st_val_d  = {out_i, 1'b0, cfg_q.acc, cfg_q.mode, cfg_q.bcd};
    end

    if (cfg_wr_i) begin
      cfg_d   = chan_cfg_t'(cfg_byte_i[5:0]);
      rd_hi_d = 1'b0;
      wr_hi_d = 1'b0;
    end

    // write path
    if (data_wr_i) begin
      case (cfg_q.acc)
        ACC_LO: begin
          load_o     = 1'b1;
          load_val_o = {{BYTE_W{1'b0}}, wdata_i};
        end
        ACC_HI: begin
          load_o     = 1'b1;
          load_val_o = {wdata_i, {BYTE_W{1'b0}}};
        end
        default: begin
          if (wr_hi_q) begin
            load_o     = 1'b1;
            load_val_o = {wdata_i, hold_q};
            wr_hi_d    = 1'b0;
          end else begin
            hold_d  = wdata_i;
            wr_hi_d = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '{acc: ACC_WORD, mode: 3'd0, bcd: 1'b0};
      rd_hi_q   <= 1'b0;
      wr_hi_q   <= 1'b0;
      hold_q    <= '0;
      cl_pend_q <= ACC_LATCH;
      cl_val_q  <= '0;
      st_pend_q <= 1'b0;
      st_val_q  <= '0;
    end else begin
      cfg_q     <= cfg_d;
      rd_hi_q   <= rd_hi_d;
      wr_hi_q   <= wr_hi_d;
      hold_q    <= hold_d;
      cl_pend_q <= cl_pend_d;
      cl_val_q  <= cl_val_d;
      st_pend_q <= st_pend_d;
      st_val_q  <= st_val_d;
    end
  end

  assign cl_pend_o = cl_pend_q;
  assign cl_val_o  = cl_val_q;
  assign st_pend_o = st_pend_q;
  assign st_val_o  = st_val_q;
endmodule

// File: rtl/pit_regs_top.sv
module pit_regs_top
  import pit_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  output logic              bus_ack_o,
  input  logic [NUM_CH-1:0] tick_i,
  output logic [NUM_CH-1:0] out_o
);
  logic                           ctl_wr, readback;
  logic [NUM_CH-1:0][BYTE_W-1:0] chan_rdata;
  logic [NUM_CH-1:0][1:0]        cl_pend_w;
  logic [NUM_CH-1:0][CNT_W-1:0]  cl_val_w;
  logic [NUM_CH-1:0]             st_pend_w;
  logic [NUM_CH-1:0][BYTE_W-1:0] st_val_w;
  logic [BYTE_W-1:0]             rdata_q, rdata_d;
  logic                          ack_q;

  assign ctl_wr   = bus_sel_i && bus_wr_i && bus_addr_i == CTL_ADDR;
  assign readback = bus_wdata_i[7:6] == 2'd3;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic             named, cfg_wr, cnt_latch, st_latch, data_wr, data_rd, load;
    logic [CNT_W-1:0] load_val, count;
    logic             out_bit;

    assign named     = ctl_wr && !readback && bus_wdata_i[7:6] == 2'(ch);
    assign cfg_wr    = named && bus_wdata_i[5:4] != ACC_LATCH;
    assign cnt_latch = (named && bus_wdata_i[5:4] == ACC_LATCH) ||
                       (ctl_wr && readback && bus_wdata_i[ch+1] && !bus_wdata_i[5]);
    assign st_latch  = ctl_wr && readback && bus_wdata_i[ch+1] && !bus_wdata_i[4];
    assign data_wr   = bus_sel_i &&  bus_wr_i && bus_addr_i == 2'(ch);
    assign data_rd   = bus_sel_i && !bus_wr_i && bus_addr_i == 2'(ch);

    pit_chan_regs u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_i(cfg_wr), .cfg_byte_i(bus_wdata_i),
      .cnt_latch_i(cnt_latch), .st_latch_i(st_latch),
      .data_wr_i(data_wr), .data_rd_i(data_rd), .wdata_i(bus_wdata_i),
      .count_i(count), .out_i(out_bit),
      .rdata_o(chan_rdata[ch]), .load_o(load), .load_val_o(load_val),
      .cl_pend_o(cl_pend_w[ch]), .cl_val_o(cl_val_w[ch]),
      .st_pend_o(st_pend_w[ch]), .st_val_o(st_val_w[ch])
    );

    pit_down_counter u_cnt (
      .clk(clk), .rst_n(rst_n),
      .load_i(load), .load_val_i(load_val), .tick_i(tick_i[ch]),
      .count_o(count), .out_o(out_bit)
    );

    assign out_o[ch] = out_bit;
  end

  always_comb begin
    rdata_d = '0;
    if (bus_sel_i && !bus_wr_i) begin
      case (bus_addr_i)
        2'd0:    rdata_d = chan_rdata[0];
        2'd1:    rdata_d = chan_rdata[1];
        2'd2:    rdata_d = chan_rdata[2];
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      ack_q   <= bus_sel_i;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign bus_ack_o   = ack_q;
endmodule

// File: rtl/pit_regs_chk.sv
module pit_regs_chk
  import pit_regs_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          sel,
  input logic                          wr,
  input logic [1:0]                    addr,
  input logic                          ack,
  input logic [BYTE_W-1:0]             rdata,
  input logic [NUM_CH-1:0]             tick,
  input logic [NUM_CH-1:0]             out,
  input logic [NUM_CH-1:0][1:0]        cl_pend,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cl_val,
  input logic [NUM_CH-1:0]             st_pend,
  input logic [NUM_CH-1:0][BYTE_W-1:0] st_val
);
  // R1
  ack_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n) sel |=> ack);
  // R1
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) !sel |=> !ack);
  // R1
  ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && addr == CTL_ADDR) |=> rdata == '0);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R4
    cnt_latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_pend[ch] != 2'd0 && !(sel && !wr && addr == 2'(ch))) |=> $stable(cl_val[ch]));
    // R4
    st_latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_pend[ch] && !(sel && !wr && addr == 2'(ch))) |=> (st_pend[ch] && $stable(st_val[ch])));
    // R12
    out_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out[ch]) |-> $past(tick[ch]));
  end
endmodule

bind pit_regs_top pit_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(bus_sel_i), .wr(bus_wr_i), .addr(bus_addr_i),
  .ack(bus_ack_o), .rdata(bus_rdata_o), .tick(tick_i), .out(out_o),
  .cl_pend(cl_pend_w), .cl_val(cl_val_w), .st_pend(st_pend_w), .st_val(st_val_w)
);

// File: tb/pit_regs_top_tb.sv
module pit_regs_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [2:0] tick = 3'b000;
  logic [7:0] rdata;
  logic       ack;
  logic [2:0] outb;

  int n_chk = 0;
  int n_fail = 0;

  // bench model of the requirements
  logic [15:0] m_cnt[3];
  logic        m_out[3];
  logic [1:0]  m_acc[3];
  logic [2:0]  m_mode[3];
  logic        m_bcd[3];
  logic        m_rdhi[3], m_wrhi[3];
  logic [7:0]  m_hold[3];
  logic [1:0]  m_clp[3];
  logic [15:0] m_clv[3];
  logic        m_stp[3];
  logic [7:0]  m_stv[3];

  always #10 clk = ~clk;

  pit_regs_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_ack_o(ack), .tick_i(tick), .out_o(outb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 3; c++) begin
      m_cnt[c] = 16'h0; m_out[c] = 1'b0; m_acc[c] = 2'd3; m_mode[c] = 3'd0; m_bcd[c] = 1'b0;
      m_rdhi[c] = 1'b0; m_wrhi[c] = 1'b0; m_hold[c] = 8'h0;
      m_clp[c] = 2'd0; m_clv[c] = 16'h0; m_stp[c] = 1'b0; m_stv[c] = 8'h0;
    end
  endtask

  task automatic latch_cnt(input int c);
    if (m_clp[c] == 2'd0) begin m_clp[c] = m_acc[c]; m_clv[c] = m_cnt[c]; end
  endtask

  task automatic latch_st(input int c);
    if (!m_stp[c]) begin
      m_stp[c] = 1'b1;
      m_stv[c] = {m_out[c], 1'b0, m_acc[c], m_mode[c], m_bcd[c]};
    end
  endtask

  task automatic model(input logic s, input logic w, input logic [1:0] a,
                       input logic [7:0] d, input logic [2:0] tk, output logic [7:0] er);
    logic        ld[3];
    logic [15:0] lv[3];
    er = 8'h00;
    for (int c = 0; c < 3; c++) begin ld[c] = 1'b0; lv[c] = 16'h0; end
    if (s && w && a == 2'd3) begin
      if (d[7:6] == 2'd3) begin
        for (int c = 0; c < 3; c++) if (d[c+1]) begin
          if (!d[5]) latch_cnt(c);
          if (!d[4]) latch_st(c);
        end
      end else if (d[5:4] == 2'd0) latch_cnt(int'(d[7:6]));
      else begin
        m_acc[d[7:6]] = d[5:4]; m_mode[d[7:6]] = d[3:1]; m_bcd[d[7:6]] = d[0];
        m_rdhi[d[7:6]] = 1'b0; m_wrhi[d[7:6]] = 1'b0;
      end
    end else if (s && w) begin
      case (m_acc[a])
        2'd1: begin ld[a] = 1'b1; lv[a] = {8'h00, d}; end
        2'd2: begin ld[a] = 1'b1; lv[a] = {d, 8'h00}; end
        default: if (m_wrhi[a]) begin ld[a] = 1'b1; lv[a] = {d, m_hold[a]}; m_wrhi[a] = 1'b0; end
                 else begin m_hold[a] = d; m_wrhi[a] = 1'b1; end
      endcase
    end else if (s && a != 2'd3) begin
      if (m_stp[a]) begin er = m_stv[a]; m_stp[a] = 1'b0; end
      else if (m_clp[a] == 2'd1) begin er = m_clv[a][7:0]; m_clp[a] = 2'd0; end
      else if (m_clp[a] == 2'd2) begin er = m_clv[a][15:8]; m_clp[a] = 2'd0; end
      else if (m_clp[a] == 2'd3) begin er = m_clv[a][7:0]; m_clp[a] = 2'd2; end
      else if (m_acc[a] == 2'd1) er = m_cnt[a][7:0];
      else if (m_acc[a] == 2'd2) er = m_cnt[a][15:8];
      else begin er = m_rdhi[a] ? m_cnt[a][15:8] : m_cnt[a][7:0]; m_rdhi[a] = ~m_rdhi[a]; end
    end
    for (int c = 0; c < 3; c++) begin
      if (ld[c]) begin m_cnt[c] = lv[c]; m_out[c] = 1'b0; end
      else if (tk[c]) begin
        if (m_cnt[c] == 16'h1) m_out[c] = 1'b1;
        m_cnt[c] = m_cnt[c] - 16'h1;
      end
    end
  endtask

  // one bus cycle: drive at the falling edge, check after the next rising edge
  task automatic op(input logic s, input logic w, input logic [1:0] a,
                    input logic [7:0] d, input logic [2:0] tk, input string req);
    logic [7:0] er;
    logic [2:0] eo;
    sel = s; wr = w; addr = a; wdata = d; tick = tk;
    model(s, w, a, d, tk, er);
    eo = {m_out[2], m_out[1], m_out[0]};
    @(posedge clk);
    @(negedge clk);
    chk(ack == s, {req, " ack"}, ack, s);
    if (s && !w) chk(rdata == er, {req, " rdata"}, rdata, er);
    chk(outb == eo, {req, " out"}, outb, eo);
  endtask

  task automatic wr_ctl(input logic [7:0] d, input string req); op(1, 1, 2'd3, d, 3'b0, req); endtask
  task automatic wr_dat(input logic [1:0] a, input logic [7:0] d, input string req); op(1, 1, a, d, 3'b0, req); endtask
  task automatic rd(input logic [1:0] a, input string req); op(1, 0, a, 8'h00, 3'b0, req); endtask
  task automatic idle(input logic [2:0] tk, input string req); op(0, 0, 2'd0, 8'h00, tk, req); endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(ack == 1'b0 && outb == 3'b000, "R13 reset outputs", {ack, outb}, 0);
    // R13: reset config seen through status read-back of every channel (expect 0x30)
    wr_ctl(8'hEE, "R13");
    rd(2'd0, "R13 status ch0");
    chk(rdata == 8'h30, "R6 status literal", rdata, 8'h30);
    rd(2'd1, "R13"); rd(2'd2, "R13");
    rd(2'd0, "R13 live lo"); rd(2'd0, "R13 live hi");
    // R1: control port reads zero
    rd(2'd3, "R1");
    chk(rdata == 8'h00, "R1 ctl read literal", rdata, 0);
    // R10: word write to ch0, then live read alternation (R9)
    wr_dat(2'd0, 8'h34, "R10"); wr_dat(2'd0, 8'h12, "R10");
    rd(2'd0, "R9"); chk(rdata == 8'h34, "R9 lo literal", rdata, 8'h34);
    rd(2'd0, "R9"); chk(rdata == 8'h12, "R9 hi literal", rdata, 8'h12);
    // R3 / R4: latch, run counter, re-latch ignored
    wr_ctl(8'h00, "R3");
    repeat (5) idle(3'b001, "R12");
    wr_ctl(8'h00, "R4");
    rd(2'd0, "R8"); rd(2'd0, "R8");
    chk(rdata == 8'h12, "R4 latched hi literal", rdata, 8'h12);
    rd(2'd0, "R8 released");
    // R2: config with mode/bcd, sequencers reset, status checked (R6)
    wr_dat(2'd0, 8'h55, "R2 half write");
    wr_ctl(8'h3B, "R2");
    wr_dat(2'd0, 8'h07, "R2"); wr_dat(2'd0, 8'h00, "R2");
    wr_ctl(8'hE2, "R5");
    rd(2'd0, "R6"); chk(rdata == 8'h3B, "R6 status literal", rdata, 8'h3B);
    // R7: status and count both pending, status first
    wr_ctl(8'hC2, "R5");
    wr_ctl(8'hE2, "R4 status relatch ignored");
    rd(2'd0, "R7"); rd(2'd0, "R7"); rd(2'd0, "R7"); rd(2'd0, "R7");
    // R11: zero load is 65536
    wr_ctl(8'h50, "R2");
    wr_dat(2'd1, 8'h00, "R11");
    idle(3'b010, "R11");
    wr_ctl(8'h40, "R11"); rd(2'd1, "R11");
    chk(rdata == 8'hFF, "R11 lo literal", rdata, 8'hFF);
    wr_ctl(8'h60, "R8"); rd(2'd1, "R11 hi");
    // R12: count to zero sets out, load clears it
    wr_ctl(8'hB0, "R2");
    wr_dat(2'd2, 8'h03, "R10"); wr_dat(2'd2, 8'h00, "R10");
    repeat (3) idle(3'b100, "R12");
    chk(outb[2] == 1'b1, "R12 out literal", outb, 3'b100);
    wr_ctl(8'hE8, "R6"); rd(2'd2, "R6 out in status");
    op(1, 1, 2'd2, 8'h09, 3'b100, "R12"); op(1, 1, 2'd2, 8'h00, 3'b100, "R12 load beats tick");
    // random mix
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [7:0] d;
      logic [2:0] tk;
      r = int'($urandom % 10);
      d = 8'($urandom);
      tk = ($urandom % 3 == 0) ? 3'($urandom) : 3'b000;
      if (r < 2) op(1, 1, 2'd3, d, tk, "R5 random ctl");
      else if (r < 4) op(1, 1, 2'($urandom % 3), d, tk, "R10 random write");
      else if (r < 8) op(1, 0, 2'($urandom), 8'h00, tk, "R7 random read");
      else op(0, 0, 2'd0, 8'h00, tk, "R12 random idle");
    end
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule